// File: doc/BRIEF.md
# Home-Node Atomic Action Sequencer

This block sits at the point of coherence of a coherent cache and turns one atomic request into the ordered list of protocol steps that carry it out. The request says whether the atomic returns a value. Side inputs say whether this cache is the home node, whether atomics allocate locally, whether completion of an atomic without return is sent apart from the buffer-ID response, what class of state the line is in, how many upstream sharers the directory records, and whether upstream data may be dirty. From these the block picks one of five handling paths and builds the step list for it.

The steps go out one at a time on an action port. A blocking step stays on the port until the downstream engine reports it done. A non-blocking step retires in the cycle it is shown, so the step after it appears on the next cycle without waiting. While a list is running, new requests are stalled. When the last step retires, a one-cycle done pulse is raised. The block also keeps a writeback flag, chooses whether data returned to the requester is the pre-operation or the updated value, and reports whether the line is to be invalidated and whether a directory entry is allocated.

Top module: `atom_seq_top`

## Requirements
- R1: Path choice: with `req_home`=0 the forwarding path is used. With `req_home`=1, line class 1 (locally unique) or 2 (locally shared) uses the local-write path; class 3 (held only upstream) uses local-write when `req_alloc_cfg`=1, else writeback; class 0 (invalid) uses allocating-miss when `req_alloc_cfg`=1, else non-allocating-miss.
- R2: Action codes are 0 snoop-invalidate, 1 snoop-invalidate with data return, 2 downstream read, 3 buffer-ID response, 4 combined completion and buffer-ID, 5 separate completion, 6 completion with data, 7 front-end pipe write, 8 atomic delay, 9 fill check, 10 back-end pipe write, 11 tag write, 12 downstream write request, 13 downstream write data, 14 forwarded atomic, 15 forwarded data. Local-write list: optional snoop, response group, then 8, 9, 10 and 11, all blocking.
- R3: Writeback list: optional snoop, response group, then 8, 12, 10, 13 blocking and 11 non-blocking.
- R4: The optional snoop appears only on local-write and writeback paths and only with a nonzero sharer count: code 0 when `req_up_dirty`=1, code 1 otherwise.
- R5: Both miss lists start with a blocking 2 and the response group. The allocating miss ends with blocking 8, 9, 10, 11; the non-allocating miss ends with blocking 8, 10, 12, 13 and non-blocking 11.
- R6: Response group (blocking unless stated): with return, 3, 7 non-blocking, 6; without return and `req_split_comp`=1, 3, 7 non-blocking, 5 non-blocking; without return and split clear, 4, 7 non-blocking. On the forwarding path the 7 is left out of the group.
- R7: Forwarding list: 14 blocking, 7 non-blocking, then with return 3, 15, 6, or without return the no-return group, then 10 blocking and 11 non-blocking.
- R8: The first step of an accepted request is on the port in the cycle after acceptance; a blocking step holds until `act_done`=1 in a cycle it is shown, a non-blocking step retires in its own cycle regardless of `act_done`.
- R9: `req_ready` is low from acceptance until the last step retires; requests seen while it is low are ignored. `seq_done` is high for exactly the cycle after the last retire, and low after reset.
- R10: `wb_flag` is cleared at reset and when a request is accepted, and set from the cycle after a code-12 step retires.
- R11: `ret_old_data` is high only while a with-return list is running and `wb_flag` is clear.
- R12: From the cycle after acceptance until the next acceptance, `line_inval` is high for forwarding, writeback and non-allocating-miss paths, and `dir_alloc` is high only for the allocating miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_ret | input | 1 | Atomic returns a value |
| req_home | input | 1 | This cache is the home node |
| req_alloc_cfg | input | 1 | Atomics allocate locally |
| req_split_comp | input | 1 | Separate completion for no-return atomics |
| req_state | input | 2 | Line class: 0 invalid, 1 unique, 2 shared, 3 upstream only |
| req_sharers | input | SHR_W | Directory sharer count |
| req_up_dirty | input | 1 | Upstream data may be dirty |
| act_valid | output | 1 | A step is on the action port |
| act_code | output | 4 | Step code |
| act_nb | output | 1 | Step is non-blocking |
| act_done | input | 1 | Current blocking step finished |
| seq_done | output | 1 | Pulse after the last step retires |
| wb_flag | output | 1 | Downstream write request issued |
| ret_old_data | output | 1 | Returned data is the pre-operation value |
| line_inval | output | 1 | Line ends invalid |
| dir_alloc | output | 1 | Directory entry allocated |

## Verification
The assertions take for granted that `act_done` only has meaning while a step is shown, and that request attributes matter only in the accepting cycle; both are free-running in the stimulus, which drives `act_done` from a pseudo-random sequence and raises `req_valid` with random attributes while a list runs. Every combination of home, line class, allocation, return, split completion, sharer presence and dirtiness is issued once, with all inputs changed on the falling edge so each edge sees stable values.

// File: rtl/atom_seq_pkg.sv
package atom_seq_pkg;

    localparam int unsigned MAX_ACTS = 12;
    localparam int unsigned CODE_W   = 4;

    typedef enum logic [CODE_W-1:0] {
        A_SNP_INV   = 4'd0,
        A_SNP_FETCH = 4'd1,
        A_RD_DN     = 4'd2,
        A_BUFID     = 4'd3,
        A_COMP_BUF  = 4'd4,
        A_COMP      = 4'd5,
        A_COMP_DATA = 4'd6,
        A_FE_WR     = 4'd7,
        A_AT_DELAY  = 4'd8,
        A_FILL_CHK  = 4'd9,
        A_BE_WR     = 4'd10,
        A_TAG_WR    = 4'd11,
        A_WR_DN     = 4'd12,
        A_WR_DATA   = 4'd13,
        A_FWD_ATOM  = 4'd14,
        A_FWD_DATA  = 4'd15
    } act_e;

    typedef enum logic [1:0] {
        LC_INV = 2'd0,
        LC_OWN = 2'd1,
        LC_SHR = 2'd2,
        LC_UP  = 2'd3
    } line_cls_e;

    typedef enum logic [2:0] {
        P_FWD     = 3'd0,
        P_LOCAL   = 3'd1,
        P_WBACK   = 3'd2,
        P_MISS_AL = 3'd3,
        P_MISS_NA = 3'd4
    } path_e;

    typedef struct packed {
        act_e code;
        logic nb;
    } act_ent_t;

    function automatic act_ent_t mk_ent(act_e c, logic nb);
        act_ent_t e;
        e.code = c;
        e.nb   = nb;
        return e;
    endfunction

    function automatic logic path_drops_line(path_e p);
        return (p == P_FWD) || (p == P_WBACK) || (p == P_MISS_NA);
    endfunction

endpackage

// File: rtl/atom_path_sel.sv
module atom_path_sel
    import atom_seq_pkg::*;
#(
    parameter int unsigned SHR_W = 4
) (
    input  logic             home,
    input  logic             alloc_cfg,
    input  logic [1:0]       state,
    input  logic [SHR_W-1:0] sharers,
    input  logic             up_dirty,
    output path_e            path,
    output logic             snp_en,
    output logic             snp_fetch
);
    line_cls_e cls;

    always_comb begin
        cls = line_cls_e'(state);
        if (!home) begin
            path = P_FWD;
        end else begin
            unique case (cls)
                LC_OWN, LC_SHR: path = P_LOCAL;
                LC_UP:          path = alloc_cfg ? P_LOCAL : P_WBACK;
                default:        path = alloc_cfg ? P_MISS_AL : P_MISS_NA;
            endcase
        end
        snp_en    = ((path == P_LOCAL) || (path == P_WBACK)) && (|sharers);
        snp_fetch = !up_dirty;
    end

endmodule

// File: rtl/atom_list_build.sv
module atom_list_build
    import atom_seq_pkg::*;
#(
    parameter int unsigned DEPTH = MAX_ACTS,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  path_e            path,
    input  logic             snp_en,
    input  logic             snp_fetch,
    input  logic             has_ret,
    input  logic             split,
    output act_ent_t         lst [DEPTH],
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] n;
    logic             fwd;

    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) lst[i] = mk_ent(A_TAG_WR, 1'b0);
        n   = '0;
        fwd = (path == P_FWD);

        // leading part
        if (fwd) begin
            lst[n] = mk_ent(A_FWD_ATOM, 1'b0); n = n + 1'b1;
            lst[n] = mk_ent(A_FE_WR, 1'b1);    n = n + 1'b1;
        end else if ((path == P_MISS_AL) || (path == P_MISS_NA)) begin
            lst[n] = mk_ent(A_RD_DN, 1'b0);    n = n + 1'b1;
        end else if (snp_en) begin
            lst[n] = mk_ent(snp_fetch ? A_SNP_FETCH : A_SNP_INV, 1'b0); n = n + 1'b1;
        end

        // response group
        if (has_ret) begin
            lst[n] = mk_ent(A_BUFID, 1'b0); n = n + 1'b1;
            if (fwd) begin
                lst[n] = mk_ent(A_FWD_DATA, 1'b0); n = n + 1'b1;
            end else begin
                lst[n] = mk_ent(A_FE_WR, 1'b1); n = n + 1'b1;
            end
            lst[n] = mk_ent(A_COMP_DATA, 1'b0); n = n + 1'b1;
        end else if (split) begin
            lst[n] = mk_ent(A_BUFID, 1'b0); n = n + 1'b1;
            if (!fwd) begin
                lst[n] = mk_ent(A_FE_WR, 1'b1); n = n + 1'b1;
            end
            lst[n] = mk_ent(A_COMP, 1'b1); n = n + 1'b1;
        end else begin
            lst[n] = mk_ent(A_COMP_BUF, 1'b0); n = n + 1'b1;
            if (!fwd) begin
                lst[n] = mk_ent(A_FE_WR, 1'b1); n = n + 1'b1;
            end
        end

        // closing part
        unique case (path)
            P_FWD: begin
                lst[n] = mk_ent(A_BE_WR, 1'b0);  n = n + 1'b1;
                lst[n] = mk_ent(A_TAG_WR, 1'b1); n = n + 1'b1;
            end
            P_WBACK: begin
                lst[n] = mk_ent(A_AT_DELAY, 1'b0); n = n + 1'b1;
                lst[n] = mk_ent(A_WR_DN, 1'b0);    n = n + 1'b1;
                lst[n] = mk_ent(A_BE_WR, 1'b0);    n = n + 1'b1;
                lst[n] = mk_ent(A_WR_DATA, 1'b0);  n = n + 1'b1;
                lst[n] = mk_ent(A_TAG_WR, 1'b1);   n = n + 1'b1;
            end
            P_MISS_NA: begin
                lst[n] = mk_ent(A_AT_DELAY, 1'b0); n = n + 1'b1;
                lst[n] = mk_ent(A_BE_WR, 1'b0);    n = n + 1'b1;
                lst[n] = mk_ent(A_WR_DN, 1'b0);    n = n + 1'b1;
                lst[n] = mk_ent(A_WR_DATA, 1'b0);  n = n + 1'b1;
                lst[n] = mk_ent(A_TAG_WR, 1'b1);   n = n + 1'b1;
            end
            default: begin
                lst[n] = mk_ent(A_AT_DELAY, 1'b0); n = n + 1'b1;
                lst[n] = mk_ent(A_FILL_CHK, 1'b0); n = n + 1'b1;
                lst[n] = mk_ent(A_BE_WR, 1'b0);    n = n + 1'b1;
                lst[n] = mk_ent(A_TAG_WR, 1'b0);   n = n + 1'b1;
            end
        endcase
        cnt = n;
    end

endmodule

// File: rtl/atom_act_queue.sv
module atom_act_queue
    import atom_seq_pkg::*;
#(
    parameter int unsigned DEPTH = MAX_ACTS,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  act_ent_t         load_lst [DEPTH],
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             act_done,
    output logic             busy,
    output act_ent_t         head,
    output logic             wr_retire,
    output logic             seq_done
);
    act_ent_t         mem [DEPTH];
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             retire;

    always_comb begin
        head      = busy ? mem[idx] : mk_ent(A_SNP_INV, 1'b0);
        retire    = busy && (head.nb || act_done);
        wr_retire = retire && (head.code == A_WR_DN);
    end

    always_ff @(posedge clk) begin
        if (load) mem <= load_lst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                idx  <= '0;
                cnt  <= load_cnt;
            end else if (retire) begin
                if (idx == cnt - 1'b1) begin
                    busy     <= 1'b0;
                    seq_done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/atom_seq_top.sv
module atom_seq_top
    import atom_seq_pkg::*;
#(
    parameter int unsigned SHR_W = 4,
    parameter int unsigned DEPTH = MAX_ACTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_ret,
    input  logic             req_home,
    input  logic             req_alloc_cfg,
    input  logic             req_split_comp,
    input  logic [1:0]       req_state,
    input  logic [SHR_W-1:0] req_sharers,
    input  logic             req_up_dirty,
    output logic             act_valid,
    output logic [3:0]       act_code,
    output logic             act_nb,
    input  logic             act_done,
    output logic             seq_done,
    output logic             wb_flag,
    output logic             ret_old_data,
    output logic             line_inval,
    output logic             dir_alloc
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    path_e            path;
    logic             snp_en, snp_fetch;
    act_ent_t         lst [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             busy, load, wr_retire;
    act_ent_t         head;
    logic             ret_q;

    atom_path_sel #(.SHR_W(SHR_W)) i_sel (
        .home(req_home), .alloc_cfg(req_alloc_cfg), .state(req_state),
        .sharers(req_sharers), .up_dirty(req_up_dirty),
        .path(path), .snp_en(snp_en), .snp_fetch(snp_fetch)
    );

    atom_list_build #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_build (
        .path(path), .snp_en(snp_en), .snp_fetch(snp_fetch),
        .has_ret(req_ret), .split(req_split_comp), .lst(lst), .cnt(cnt)
    );

    atom_act_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_q (
        .clk(clk), .rst(rst), .load(load), .load_lst(lst), .load_cnt(cnt),
        .act_done(act_done), .busy(busy), .head(head),
        .wr_retire(wr_retire), .seq_done(seq_done)
    );

    assign load      = req_valid && !busy;
    assign req_ready = !busy;
    assign act_valid = busy;
    assign act_code  = head.code;
    assign act_nb    = head.nb;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_flag    <= 1'b0;
            ret_q      <= 1'b0;
            line_inval <= 1'b0;
            dir_alloc  <= 1'b0;
        end else if (load) begin
            wb_flag    <= 1'b0;
            ret_q      <= req_ret;
            line_inval <= path_drops_line(path);
            dir_alloc  <= (path == P_MISS_AL);
        end else if (wr_retire) begin
            wb_flag <= 1'b1;
        end
    end

    assign ret_old_data = busy && ret_q && !wb_flag;

endmodule

// File: rtl/atom_seq_chk.sv
module atom_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       act_valid,
    input logic [3:0] act_code,
    input logic       act_nb,
    input logic       act_done,
    input logic       seq_done,
    input logic       wb_flag,
    input logic       ret_old_data
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    assert_done_after_step_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> $past(act_valid));

    assert_block_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !act_nb && !act_done) |=> (act_valid && $stable(act_code)));

    assert_wb_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_flag) |-> $past(act_valid && act_code == 4'd12));

    assert_wb_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_flag) |-> $past(req_valid && req_ready));

    assert_old_data_R11: assert property (@(posedge clk) disable iff (rst)
        wb_flag |-> !ret_old_data);

endmodule

bind atom_seq_top atom_seq_chk i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .act_valid(act_valid), .act_code(act_code), .act_nb(act_nb),
    .act_done(act_done), .seq_done(seq_done), .wb_flag(wb_flag),
    .ret_old_data(ret_old_data)
);

// File: tb/test_atom_seq_top.sv
module test_atom_seq_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_ready, req_ret, req_home, req_alloc_cfg, req_split_comp;
    logic [1:0] req_state;
    logic [3:0] req_sharers;
    logic       req_up_dirty;
    logic       act_valid, act_nb, act_done, seq_done;
    logic [3:0] act_code;
    logic       wb_flag, ret_old_data, line_inval, dir_alloc;

    always #2.5 clk = ~clk;

    atom_seq_top i_atom_seq_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ret(req_ret), .req_home(req_home), .req_alloc_cfg(req_alloc_cfg),
        .req_split_comp(req_split_comp), .req_state(req_state),
        .req_sharers(req_sharers), .req_up_dirty(req_up_dirty),
        .act_valid(act_valid), .act_code(act_code), .act_nb(act_nb),
        .act_done(act_done), .seq_done(seq_done), .wb_flag(wb_flag),
        .ret_old_data(ret_old_data), .line_inval(line_inval), .dir_alloc(dir_alloc)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int q_code[$];
    bit q_nb[$];
    bit m_busy, m_done, m_wb, m_ret, m_inval, m_dir;
    string m_tag;

    function automatic void put(int c, bit nb);
        q_code.push_back(c);
        q_nb.push_back(nb);
    endfunction

    // path numbers: 0 forward, 1 local write, 2 writeback, 3 alloc miss, 4 plain miss
    function automatic void expect_list(bit home, bit [1:0] st, bit alloc, bit ret,
                                        bit split, bit shr, bit dirty);
        int p;
        q_code.delete();
        q_nb.delete();
        if (!home) p = 0;
        else if (st == 2'd1 || st == 2'd2) p = 1;
        else if (st == 2'd3) p = alloc ? 1 : 2;
        else p = alloc ? 3 : 4;
        m_inval = (p == 0 || p == 2 || p == 4);
        m_dir   = (p == 3);
        m_tag   = (p == 0) ? "R7" : (p == 1) ? "R2" : (p == 2) ? "R3" : "R5";
        if (p == 0) begin put(14, 0); put(7, 1); end
        if (p >= 3) put(2, 0);
        if ((p == 1 || p == 2) && shr) begin
            put(dirty ? 0 : 1, 0);
            m_tag = {m_tag, "/R4"};
        end
        if (ret) begin
            put(3, 0);
            if (p == 0) put(15, 0); else put(7, 1);
            put(6, 0);
        end else if (split) begin
            put(3, 0);
            if (p != 0) put(7, 1);
            put(5, 1);
        end else begin
            put(4, 0);
            if (p != 0) put(7, 1);
        end
        m_tag = {m_tag, "/R6/R1"};
        case (p)
            0: begin put(10, 0); put(11, 1); end
            2: begin put(8, 0); put(12, 0); put(10, 0); put(13, 0); put(11, 1); end
            4: begin put(8, 0); put(10, 0); put(12, 0); put(13, 0); put(11, 1); end
            default: begin put(8, 0); put(9, 0); put(10, 0); put(11, 0); end
        endcase
    endfunction

    always @(posedge clk) begin
        m_done = 0;
        if (rst) begin
            m_busy = 0; m_wb = 0; m_ret = 0; m_inval = 0; m_dir = 0;
            q_code.delete(); q_nb.delete();
        end else if (!m_busy) begin
            if (req_valid) begin
                expect_list(req_home, req_state, req_alloc_cfg, req_ret,
                            req_split_comp, req_sharers != 0, req_up_dirty);
                m_busy = 1; m_wb = 0; m_ret = req_ret;
            end
        end else if (q_nb[0] || act_done) begin
            if (q_code[0] == 12) m_wb = 1;
            void'(q_code.pop_front());
            void'(q_nb.pop_front());
            if (q_code.size() == 0) begin m_busy = 0; m_done = 1; end
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9", "req_ready", int'(req_ready), int'(!m_busy));
        chk("R8", "act_valid", int'(act_valid), int'(m_busy));
        if (m_busy) begin
            chk(m_tag, "act_code", int'(act_code), q_code[0]);
            chk(m_tag, "act_nb", int'(act_nb), int'(q_nb[0]));
        end
        chk("R9", "seq_done", int'(seq_done), int'(m_done));
        chk("R10", "wb_flag", int'(wb_flag), int'(m_wb));
        chk("R11", "ret_old_data", int'(ret_old_data), int'(m_busy && m_ret && !m_wb));
        chk("R12", "line_inval", int'(line_inval), int'(m_inval));
        chk("R12", "dir_alloc", int'(dir_alloc), int'(m_dir));
    endtask

    logic [15:0] lf = 16'hACE1;

    initial begin
        int c = 0;
        int cyc = 0;
        rst = 1; req_valid = 0; act_done = 0;
        req_ret = 0; req_home = 0; req_alloc_cfg = 0; req_split_comp = 0;
        req_state = 0; req_sharers = 0; req_up_dirty = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();   // reset state: R9, R10, R12
        rst = 0;
        while (c < 256 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            compare_all();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            act_done = lf[0];   // R8: random completion timing
            if (!m_busy) begin
                req_valid = 1;
                req_home = c[0]; req_state = c[2:1]; req_alloc_cfg = c[3];
                req_ret = c[4]; req_split_comp = c[5];
                req_sharers = c[6] ? 4'd2 : 4'd0; req_up_dirty = c[7];
                c++;
            end else begin
                // R9: requests while busy must be ignored
                req_valid = lf[1];
                req_home = lf[2]; req_state = lf[4:3]; req_alloc_cfg = lf[5];
                req_ret = lf[6]; req_split_comp = lf[7];
                req_sharers = lf[11:8]; req_up_dirty = lf[12];
            end
        end
        if (cyc >= 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
        end
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            compare_all();
            req_valid = 0;
            act_done = 1;
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule